// File: doc/BRIEF.md
# Microcoded Sequencer with Opcode Dispatch

This block is the control unit of a small microcoded machine. Every microstate is one word of a control store. That word carries the control bits the datapath needs in that state and a link field naming the one state that follows. A second table, the dispatch table, is indexed by the opcode from the instruction register. It supplies the first microstate of the sequence that carries out each instruction. State 0 is the decode state, and dispatch is the only point where the path can fork.

Each instruction is a straight run of two to eight microstates. The last state in the run sets a fetch bit, which sends the sequencer back to the decode state. A halt bit parks the sequencer in its current state until reset.

The datapath never sees the combinational lookup of the control store. The control bits of the current state are captured in a register and driven from that register, so the output lags the state register by one clock. Both tables are loaded through plain write ports and are cleared by reset. An opcode with no dispatch entry runs a built-in single-state no-op and then returns to decode.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the state register is set to 0 (decode), `ctrl_out` is cleared to 0, every control-store word is cleared to zero and every dispatch entry is marked unprogrammed.
- R2: `ctrl_out` after a clock edge equals the control bits of the microstate that was current before that edge, and it changes only at clock edges.
- R3: In a state other than 0 or 63, with neither fetch nor halt set, the next state is the link field (bits [21:16] of the control-store word). Bits [15:0] of the word are the control bits.
- R4: In state 0 without halt, a programmed dispatch entry for `opcode` gives the next state.
- R5: In a state other than 0, control bit 0 (fetch) without halt sends the sequencer to state 0, whatever the link field holds.
- R6: Control bit 1 (halt) holds the state register and `ctrl_out` unchanged until reset, regardless of `opcode` and of the fetch bit.
- R7: In state 0, an unprogrammed opcode selects state 63. State 63 has a fixed word (control bits = only bit 0 set, link 0) that takes it back to 0, and writes to control-store address 63 have no effect.
- R8: A write through a load port changes the table entry at the clock edge where the write enable is sampled high. The new contents govern every lookup made after that edge.
- R9: `opcode` is ignored in every state except state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode from the instruction register |
| ucode_we | input | 1 | Control-store write enable |
| ucode_addr | input | 6 | Control-store word address |
| ucode_wdata | input | 22 | Word to store: link in [21:16], control bits in [15:0] |
| disp_we | input | 1 | Dispatch-table write enable |
| disp_addr | input | 8 | Opcode whose dispatch entry is written |
| disp_wdata | input | 6 | First microstate for that opcode |
| ctrl_out | output | 16 | Registered control bits for the datapath |

## Verification
The properties take reset to be synchronous and applied at the first clock edge. They assume the table contents change only through the write ports, so a state's word can be seen as a fixed fact during the cycle it is used. The stimulus loads tables only while the sequencer circles through the decode and no-op states on an unprogrammed opcode. It aligns each instruction run to the moment the no-op state's fetch word appears at the output, and it programs every microstate that a dispatched run can reach. Each sample state carries a distinct control signature, so the sequence of states can be read back from `ctrl_out` alone.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int unsigned DEF_STATE_W = 6;
    localparam int unsigned DEF_OP_W    = 8;
    localparam int unsigned DEF_CTRL_W  = 16;

    // positions of the two sequencing bits inside the control bits
    localparam int unsigned FETCH_BIT = 0;
    localparam int unsigned HALT_BIT  = 1;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_DISPATCH,
        SEL_NOP,
        SEL_RETURN,
        SEL_LINK
    } nxt_sel_e;

endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
    import useq_pkg::*;
#(
    parameter int unsigned STATE_W = DEF_STATE_W,
    parameter int unsigned CTRL_W  = DEF_CTRL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [STATE_W-1:0]        waddr,
    input  logic [CTRL_W+STATE_W-1:0] wdata,
    input  logic [STATE_W-1:0]        raddr,
    output logic [CTRL_W-1:0]         rctrl,
    output logic [STATE_W-1:0]        rnext
);

    localparam int DEPTH   = 2 ** STATE_W;
    localparam int NOP_IDX = DEPTH - 1;
    localparam int WORD_W  = CTRL_W + STATE_W;
    localparam logic [CTRL_W-1:0] NOP_CTRL = CTRL_W'(1) << FETCH_BIT;

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        if (g == NOP_IDX) begin : g_fixed
            // built-in no-op: fetch only, link back to decode
            assign words[g] = {{STATE_W{1'b0}}, NOP_CTRL};
        end else begin : g_store
            logic [WORD_W-1:0] word_d, word_q;

            always_comb begin
                word_d = word_q;
                if (we && (waddr == STATE_W'(g))) begin
                    word_d = wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= '0;
                end else begin
                    word_q <= word_d;
                end
            end

            assign words[g] = word_q;
        end
    end

    assign {rnext, rctrl} = words[raddr];

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int unsigned STATE_W = DEF_STATE_W,
    parameter int unsigned OP_W    = DEF_OP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [OP_W-1:0]    waddr,
    input  logic [STATE_W-1:0] wstart,
    input  logic [OP_W-1:0]    opcode,
    output logic               hit,
    output logic [STATE_W-1:0] start
);

    localparam int DEPTH   = 2 ** OP_W;
    localparam int ENTRY_W = STATE_W + 1;

    logic [ENTRY_W-1:0] entries [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [ENTRY_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (waddr == OP_W'(g))) begin
                ent_d = {1'b1, wstart};
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign entries[g] = ent_q;
    end

    assign {hit, start} = entries[opcode];

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int unsigned STATE_W = DEF_STATE_W
) (
    input  logic [STATE_W-1:0] state,
    input  logic               fetch,
    input  logic               halt,
    input  logic [STATE_W-1:0] link,
    input  logic               hit,
    input  logic [STATE_W-1:0] start,
    output logic [STATE_W-1:0] nxt
);

    localparam logic [STATE_W-1:0] DECODE_ST = '0;
    localparam logic [STATE_W-1:0] NOP_ST    = '1;

    nxt_sel_e sel;

    // priority: halt, then decode dispatch, then fetch, then link
    always_comb begin
        if (halt) begin
            sel = SEL_HOLD;
        end else if (state == DECODE_ST) begin
            sel = hit ? SEL_DISPATCH : SEL_NOP;
        end else if (fetch) begin
            sel = SEL_RETURN;
        end else begin
            sel = SEL_LINK;
        end
    end

    always_comb begin
        case (sel)
            SEL_HOLD:     nxt = state;
            SEL_DISPATCH: nxt = start;
            SEL_NOP:      nxt = NOP_ST;
            SEL_RETURN:   nxt = DECODE_ST;
            default:      nxt = link;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int unsigned STATE_W = DEF_STATE_W,
    parameter int unsigned OP_W    = DEF_OP_W,
    parameter int unsigned CTRL_W  = DEF_CTRL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [OP_W-1:0]           opcode,
    input  logic                      ucode_we,
    input  logic [STATE_W-1:0]        ucode_addr,
    input  logic [CTRL_W+STATE_W-1:0] ucode_wdata,
    input  logic                      disp_we,
    input  logic [OP_W-1:0]           disp_addr,
    input  logic [STATE_W-1:0]        disp_wdata,
    output logic [CTRL_W-1:0]         ctrl_out
);

    localparam logic [STATE_W-1:0] DECODE_ST = '0;
    localparam logic [STATE_W-1:0] NOP_ST    = '1;
    localparam logic [CTRL_W-1:0]  NOP_CTRL  = CTRL_W'(1) << FETCH_BIT;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [CTRL_W-1:0]  ctrl;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CTRL_W-1:0]  cur_ctrl;
    logic [STATE_W-1:0] cur_link;
    logic               disp_hit;
    logic [STATE_W-1:0] disp_start;
    logic [STATE_W-1:0] nxt_state;
    logic               cur_fetch;
    logic               cur_halt;

    useq_ctrl_store #(
        .STATE_W (STATE_W),
        .CTRL_W  (CTRL_W)
    ) i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (ucode_we),
        .waddr (ucode_addr),
        .wdata (ucode_wdata),
        .raddr (seq_q.state),
        .rctrl (cur_ctrl),
        .rnext (cur_link)
    );

    useq_dispatch #(
        .STATE_W (STATE_W),
        .OP_W    (OP_W)
    ) i_dispatch (
        .clk    (clk),
        .rst    (rst),
        .we     (disp_we),
        .waddr  (disp_addr),
        .wstart (disp_wdata),
        .opcode (opcode),
        .hit    (disp_hit),
        .start  (disp_start)
    );

    assign cur_fetch = cur_ctrl[FETCH_BIT];
    assign cur_halt  = cur_ctrl[HALT_BIT];

    useq_next #(
        .STATE_W (STATE_W)
    ) i_next (
        .state (seq_q.state),
        .fetch (cur_fetch),
        .halt  (cur_halt),
        .link  (cur_link),
        .hit   (disp_hit),
        .start (disp_start),
        .nxt   (nxt_state)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.state = nxt_state;
        seq_d.ctrl  = cur_ctrl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ctrl_out = seq_q.ctrl;

    // R1: reset parks the sequencer at decode with a cleared output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (seq_q.state == DECODE_ST && seq_q.ctrl == '0));

    // R3: plain microstates follow their link field
    p_follow_link_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state != DECODE_ST && seq_q.state != NOP_ST && !cur_fetch && !cur_halt)
        |=> seq_q.state == $past(cur_link));

    // R4: decode with a programmed entry jumps to the table's start state
    p_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == DECODE_ST && !cur_halt && disp_hit)
        |=> seq_q.state == $past(disp_start));

    // R5: fetch returns to decode
    p_fetch_return_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state != DECODE_ST && cur_fetch && !cur_halt)
        |=> seq_q.state == DECODE_ST);

    // R6: halt freezes the state register
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cur_halt |=> $stable(seq_q.state));

    // R7: unprogrammed opcode runs the built-in no-op
    p_unprog_nop_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == DECODE_ST && !cur_halt && !disp_hit)
        |=> seq_q.state == NOP_ST);

    // R7: the no-op state emits fetch only and goes back to decode
    p_nop_word_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_q.state == NOP_ST)
        |=> (seq_q.state == DECODE_ST && seq_q.ctrl == NOP_CTRL));

endmodule

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode = 8'hFF;
    logic        ucode_we = 1'b0;
    logic [5:0]  ucode_addr = '0;
    logic [21:0] ucode_wdata = '0;
    logic        disp_we = 1'b0;
    logic [7:0]  disp_addr = '0;
    logic [5:0]  disp_wdata = '0;
    logic [15:0] ctrl_out;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    useq_top i_useq_top (
        .clk         (clk),
        .rst         (rst),
        .opcode      (opcode),
        .ucode_we    (ucode_we),
        .ucode_addr  (ucode_addr),
        .ucode_wdata (ucode_wdata),
        .disp_we     (disp_we),
        .disp_addr   (disp_addr),
        .disp_wdata  (disp_wdata),
        .ctrl_out    (ctrl_out)
    );

    // ---------------- behavioural reference model ----------------
    int  m_ctrl_mem [64];
    int  m_link_mem [64];
    int  m_disp     [256];
    bit  m_valid    [256];
    int  m_state = 0;
    int  m_ctrl  = 0;
    bit  m_live  = 0;
    int  w_ctrl, w_link, n_state;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0;
            m_ctrl  = 0;
            for (int i = 0; i < 64; i++) begin
                m_ctrl_mem[i] = 0;
                m_link_mem[i] = 0;
            end
            for (int i = 0; i < 256; i++) begin
                m_disp[i]  = 0;
                m_valid[i] = 0;
            end
            m_live = 1;
        end else begin
            if (m_state == 63) begin
                w_ctrl = 1;
                w_link = 0;
            end else begin
                w_ctrl = m_ctrl_mem[m_state];
                w_link = m_link_mem[m_state];
            end
            if ((w_ctrl & 2) != 0)       n_state = m_state;
            else if (m_state == 0)       n_state = m_valid[opcode] ? m_disp[opcode] : 63;
            else if ((w_ctrl & 1) != 0)  n_state = 0;
            else                         n_state = w_link;
            m_ctrl  = w_ctrl;
            m_state = n_state;
            if (ucode_we) begin
                m_ctrl_mem[ucode_addr] = int'(ucode_wdata[15:0]);
                m_link_mem[ucode_addr] = int'(ucode_wdata[21:16]);
            end
            if (disp_we) begin
                m_disp[disp_addr]  = int'(disp_wdata);
                m_valid[disp_addr] = 1;
            end
        end
    end

    // every-cycle comparison against the model (R2)
    always @(negedge clk) begin
        if (m_live && !rst) begin
            total++;
            if (ctrl_out !== 16'(m_ctrl)) begin
                bad++;
                $display("FAIL R2 model compare actual=%h expected=%h", ctrl_out, 16'(m_ctrl));
            end
        end
    end

    // ---------------- helpers ----------------
    logic [15:0] exp_q [$];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_exp(input string tag);
        foreach (exp_q[i]) begin
            @(negedge clk);
            chk(tag, ctrl_out, exp_q[i]);
        end
    endtask

    task automatic uwrite(input int a, input int lk, input logic [15:0] c);
        ucode_we    = 1'b1;
        ucode_addr  = 6'(a);
        ucode_wdata = {6'(lk), c};
        @(negedge clk);
        ucode_we    = 1'b0;
    endtask

    task automatic dwrite(input int op, input int st);
        disp_we    = 1'b1;
        disp_addr  = 8'(op);
        disp_wdata = 6'(st);
        @(negedge clk);
        disp_we    = 1'b0;
    endtask

    // wait until the no-op word is on the output: state register is then 0
    task automatic align();
        opcode = 8'hFF;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ctrl_out == 16'h0001) return;
        end
        chk("R7 align", ctrl_out, 16'h0001);
    endtask

    function automatic logic [15:0] sig(input int s, input int flags);
        return {8'(s), 8'(flags | 4)};
    endfunction

    task automatic load_prog();
        uwrite(0, 0, sig(0, 0) & 16'h00FF);
        uwrite(4, 5, sig(4, 0));
        uwrite(5, 6, sig(5, 0));
        uwrite(6, 0, sig(6, 1));
        uwrite(10, 11, sig(10, 0));
        uwrite(11, 33, sig(11, 1));
        for (int s = 20; s < 27; s++) uwrite(s, s + 1, sig(s, 0));
        uwrite(27, 40, sig(27, 1));
        uwrite(50, 51, sig(50, 0));
        uwrite(51, 0, sig(51, 3));
        uwrite(63, 5, 16'hFFFF);
        dwrite(8'h10, 4);
        dwrite(8'h20, 10);
        dwrite(8'h30, 20);
        dwrite(8'hF0, 50);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk("R1 output cleared in reset", ctrl_out, 16'h0000);
        rst = 1'b0;
        // R1: empty tables -> decode, no-op, decode, no-op
        exp_q = '{16'h0000, 16'h0001, 16'h0000, 16'h0001};
        run_exp("R1 tables cleared");

        load_prog();

        // R3 R4: dispatch then link chain 4-5-6, fetch, dispatch again
        align();
        opcode = 8'h10;
        exp_q = '{16'h0004, 16'h0404, 16'h0504, 16'h0605, 16'h0004, 16'h0404};
        run_exp("R3 R4 dispatch and link");

        // R5: fetch in state 10? no: fetch in 11 overrides link 33
        align();
        opcode = 8'h20;
        exp_q = '{16'h0004, 16'h0A04, 16'h0B05, 16'h0004};
        run_exp("R5 fetch overrides link");

        // R5: eight-state sequence, last link 40 ignored
        align();
        opcode = 8'h30;
        exp_q = '{16'h0004, 16'h1404, 16'h1504, 16'h1604, 16'h1704,
                  16'h1804, 16'h1904, 16'h1A04, 16'h1B05, 16'h0004};
        run_exp("R5 long sequence");

        // R7: unprogrammed opcode, store write at 63 ignored
        align();
        opcode = 8'h77;
        exp_q = '{16'h0004, 16'h0001, 16'h0004, 16'h0001};
        run_exp("R7 unprogrammed opcode");

        // R9: opcode change mid-sequence has no effect until decode
        align();
        opcode = 8'h30;
        exp_q = '{16'h0004};
        run_exp("R9 start");
        opcode = 8'h10;
        exp_q = '{16'h1404, 16'h1504, 16'h1604, 16'h1704, 16'h1804,
                  16'h1904, 16'h1A04, 16'h1B05, 16'h0004, 16'h0404};
        run_exp("R9 opcode ignored outside decode");

        // R8: rewrite state 5, new word used on the next run
        align();
        uwrite(5, 6, 16'h05C4);
        align();
        opcode = 8'h10;
        exp_q = '{16'h0004, 16'h0404, 16'h05C4, 16'h0605};
        run_exp("R8 reload takes effect");

        // R6: halt with fetch set holds until reset
        align();
        opcode = 8'hF0;
        exp_q = '{16'h0004, 16'h3204, 16'h3307, 16'h3307, 16'h3307, 16'h3307};
        run_exp("R6 halt holds");
        opcode = 8'h10;
        exp_q = '{16'h3307, 16'h3307, 16'h3307};
        run_exp("R6 halt ignores opcode");

        // R1: reset leaves halt and clears the tables
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 output cleared by reset", ctrl_out, 16'h0000);
        rst = 1'b0;
        exp_q = '{16'h0000, 16'h0001, 16'h0000, 16'h0001};
        run_exp("R1 dispatch cleared after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule